// File: doc/BRIEF.md
# Multi-mode timer counter core

A 16-bit timer/counter controlled through a small register-mapped interface. One of four slow clock inputs is chosen as the timing source; each input is treated as a level signal sampled in the system clock domain, passed through a two-flop synchronizer, and its rising edges become count enables. A prescaler divides those edges by 1, 2, 4 or 8 before they advance the count.

The count runs in one of three modes. In continuous mode it covers the full 16-bit range. In up mode it runs from zero to a period value. In up/down mode it traces a triangle between zero and the period value. In up and up/down modes a period of zero halts counting; writing a nonzero period from that halted state restarts the count from zero. Software can clear the count, prescaler and direction with one command, read and overwrite the count, and observe one-cycle pulses when the count takes the period value (match) and when it returns to zero (wrap).

Top module: `tmr_core`

## Requirements
- R1: After reset, every register address reads 0 and `match_o` and `wrap_o` are low.
- R2: Control bits [1:0] pick the source input; only rising edges of the selected `src_i` bit advance the timer, and activity on the other bits leaves the count unchanged.
- R3: Control bits [3:2] hold a value n; the count takes one step per 2^n rising edges of the selected source.
- R4: Control bits [5:4] select the mode: 0 stop, 1 up, 2 continuous, 3 up/down; in stop mode source edges leave the count unchanged.
- R5: In up mode the count steps 0,1,...,P,0,... for period P; `match_o` pulses when the count becomes P and `wrap_o` when it goes from P (or above) to 0.
- R6: In continuous mode the count increments through 0xFFFF and rolls over to 0, pulsing `wrap_o` on the rollover; `match_o` pulses whenever the count becomes the period value.
- R7: In up/down mode the count climbs from 0 to P, then descends to 0 and climbs again; `match_o` pulses on reaching P and `wrap_o` on reaching 0 while descending.
- R8: In up or up/down mode a period of 0 halts the count; writing a nonzero period while halted sets the count to 0 and counting resumes upward.
- R9: Writing control with bit 6 set clears the count, the prescaler and the direction to up; bit 6 is not stored and reads back as 0.
- R10: A write to address 1 loads the count on the next clock, taking priority over a step in that cycle; address 2 is the period register, address 0 is control, address 3 reads 0.
- R11: `match_o` and `wrap_o` are single-cycle pulses, high in the same cycle that the count shows the period value or zero respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 4 | Timer source levels, sampled and edge-detected |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for read and write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| match_o | output | 1 | Pulse when the count takes the period value |
| wrap_o | output | 1 | Pulse when the count returns to zero |

## Verification
The assertions assume that register writes are the only way mode, period and count change other than by a step, so each timing property is disabled in cycles carrying a write; they also rely on the synchronizer's edge detector never producing enables on consecutive cycles. The bench honours this by writing only while all sources are idle and by toggling sources with a full high and low system cycle each, then waiting past the synchronizer latency before reading the count and comparing it and the counted pulses against closed-form expectations for sweeps of period, divider, source and mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_STOP = 2'd0,
    MODE_UP   = 2'd1,
    MODE_CONT = 2'd2,
    MODE_UPDN = 2'd3
  } mode_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_PER  = 2'd2;

  localparam int CTL_SEL_LSB = 0;
  localparam int CTL_DIV_LSB = 2;
  localparam int CTL_MODE_LSB = 4;
  localparam int CTL_CLR_BIT = 6;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic [STAGES:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-1:0], lvl_i[g]};
    end
    // top bit holds previous synchronized level
    assign rise_o[g] = sh_q[STAGES-1] & ~sh_q[STAGES];
  end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int PW = (1 << DIV_W) - 1;

  logic [PW-1:0] cnt_q, lim;

  always_comb begin
    lim = '0;
    for (int i = 0; i < PW; i++) lim[i] = (i < int'(div_i));
  end

  assign tick_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  mode_e        mode_i,
  input  logic [W-1:0] period_i,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         restart_i,
  output logic [W-1:0] cnt_o,
  output logic         match_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q, nxt;
  logic         down_q, down_n;
  logic         wrap_n, match_n, match_q, wrap_q;

  always_comb begin
    nxt    = cnt_q;
    down_n = down_q;
    wrap_n = 1'b0;
    if (tick_i) begin
      unique case (mode_i)
        MODE_UP: begin
          if (cnt_q >= period_i) begin
            nxt    = '0;
            wrap_n = 1'b1;
          end else nxt = cnt_q + 1'b1;
        end
        MODE_CONT: begin
          nxt    = cnt_q + 1'b1;
          wrap_n = (cnt_q == MAXV);
        end
        MODE_UPDN: begin
          if (!down_q) begin
            if (cnt_q >= period_i) begin
              nxt    = cnt_q - 1'b1;
              down_n = 1'b1;
            end else nxt = cnt_q + 1'b1;
          end else if (cnt_q == '0) begin
            nxt    = cnt_q + 1'b1;
            down_n = 1'b0;
          end else nxt = cnt_q - 1'b1;
          if (down_n && nxt == '0) begin
            wrap_n = 1'b1;
            down_n = 1'b0;
          end
        end
        default: ;
      endcase
    end
    match_n = tick_i && (mode_i != MODE_STOP) && (nxt == period_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      down_q  <= 1'b0;
      match_q <= 1'b0;
      wrap_q  <= 1'b0;
    end else if (clr_i || restart_i) begin
      cnt_q   <= '0;
      down_q  <= 1'b0;
      match_q <= 1'b0;
      wrap_q  <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= load_val_i;
      match_q <= 1'b0;
      wrap_q  <= 1'b0;
    end else begin
      cnt_q   <= nxt;
      down_q  <= down_n;
      match_q <= match_n;
      wrap_q  <= wrap_n;
    end
  end

  assign cnt_o   = cnt_q;
  assign match_o = match_q;
  assign wrap_o  = wrap_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W      = 16,
  parameter int N_SRC  = 4,
  parameter int STAGES = 2,
  parameter int DIV_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     rdata_o,
  output logic             match_o,
  output logic             wrap_o
);
  localparam int SEL_W = $clog2(N_SRC);

  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] div_q;
  mode_e            mode_q;
  logic [W-1:0]     period_q, cnt;
  logic [N_SRC-1:0] rise;
  logic             wr_ctl, wr_cnt, wr_per, clr, restart, cyc_mode, halted, run, tick;

  assign wr_ctl   = we_i && (addr_i == ADDR_CTRL);
  assign wr_cnt   = we_i && (addr_i == ADDR_CNT);
  assign wr_per   = we_i && (addr_i == ADDR_PER);
  assign clr      = wr_ctl && wdata_i[CTL_CLR_BIT];
  assign cyc_mode = (mode_q == MODE_UP) || (mode_q == MODE_UPDN);
  assign halted   = cyc_mode && (period_q == '0);
  assign restart  = wr_per && halted && (wdata_i != '0);
  assign run      = (mode_q != MODE_STOP) && !halted;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= '0;
      div_q    <= '0;
      mode_q   <= MODE_STOP;
      period_q <= '0;
    end else begin
      if (wr_ctl) begin
        sel_q  <= wdata_i[CTL_SEL_LSB +: SEL_W];
        div_q  <= wdata_i[CTL_DIV_LSB +: DIV_W];
        mode_q <= mode_e'(wdata_i[CTL_MODE_LSB +: 2]);
      end
      if (wr_per) period_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o = '0;
        rdata_o[CTL_SEL_LSB +: SEL_W]  = sel_q;
        rdata_o[CTL_DIV_LSB +: DIV_W]  = div_q;
        rdata_o[CTL_MODE_LSB +: 2]     = mode_q;
      end
      ADDR_CNT: rdata_o = cnt;
      ADDR_PER: rdata_o = period_q;
      default:  rdata_o = '0;
    endcase
  end

  tmr_edge_sync #(.N(N_SRC), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (src_i),
    .rise_o(rise)
  );

  tmr_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr || restart),
    .en_i  (rise[sel_q] && run),
    .div_i (div_q),
    .tick_o(tick)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .mode_i    (mode_q),
    .period_i  (period_q),
    .clr_i     (clr),
    .load_i    (wr_cnt),
    .load_val_i(wdata_i),
    .restart_i (restart),
    .cnt_o     (cnt),
    .match_o   (match_o),
    .wrap_o    (wrap_o)
  );
endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         we_i,
  input logic [W-1:0] cnt_i,
  input logic [W-1:0] period_i,
  input mode_e        mode_i,
  input logic         tick_i,
  input logic         match_i,
  input logic         wrap_i
);
  AST_MATCH_AT_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |-> (cnt_i == period_i)); // R11
  AST_WRAP_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |-> (cnt_i == '0)); // R11
  AST_MATCH_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> !match_i); // R11
  AST_WRAP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> !wrap_i); // R11
  AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STOP && !we_i) |=> $stable(cnt_i)); // R4
  AST_ZERO_PERIOD_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == MODE_UP || mode_i == MODE_UPDN) && period_i == '0 && !we_i) |=> $stable(cnt_i)); // R8
  AST_UP_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_UP && !we_i && cnt_i <= period_i) |=> (cnt_i <= period_i)); // R5
  AST_CONT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CONT && tick_i && !we_i) |=> (cnt_i == $past(cnt_i) + 1'b1)); // R6
endmodule

bind tmr_core tmr_core_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .cnt_i   (cnt),
  .period_i(period_q),
  .mode_i  (mode_q),
  .tick_i  (tick),
  .match_i (match_o),
  .wrap_i  (wrap_o)
);

// File: tb/tmr_core_tb.sv
`timescale 1ns/1ps
module tmr_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        match, wrap;
  int checks = 0, errors = 0, n_match = 0, n_wrap = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .match_o(match), .wrap_o(wrap)
  );

  always @(negedge clk) begin
    if (match) n_match++;
    if (wrap)  n_wrap++;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    @(negedge clk);
    addr = a;
    #1 v = int'(rdata);
  endtask

  task automatic pulses(int n, logic [3:0] mask);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); src = mask;
      @(negedge clk); src = '0;
    end
    repeat (8) @(negedge clk);
  endtask

  // ctrl: [1:0] source, [3:2] divider, [5:4] mode, [6] clear
  function automatic logic [15:0] ctl(int sel, int dv, int md, bit c);
    return 16'((c << 6) | (md << 4) | (dv << 2) | sel);
  endfunction

  task automatic start(int md, int dv, int sel, int per);
    wr(2'd0, ctl(0, 0, 0, 1'b1));
    wr(2'd2, 16'(per));
    wr(2'd0, ctl(sel, dv, md, 1'b1));
    repeat (2) @(negedge clk);
    n_match = 0; n_wrap = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, t, r, ec, ew, em;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reset read", v, 0);
    end
    chk("R1 reset match", int'(match), 0);
    chk("R1 reset wrap", int'(wrap), 0);

    // R4 stop mode holds
    wr(2'd0, ctl(0, 0, 0, 1'b0));
    pulses(5, 4'b0001);
    rd(2'd1, v); chk("R4 stop holds count", v, 0);

    // R5 R7 R3 R2 sweeps
    for (int md = 1; md <= 3; md += 2) begin
      for (int p = 1; p <= 4; p++) begin
        for (int dv = 0; dv < 4; dv++) begin
          t = 2 * p + 3;
          start(md, dv, dv, p);
          pulses(t << dv, 4'(1 << dv));
          if (md == 1) begin
            ec = t % (p + 1); ew = t / (p + 1); em = (t + 1) / (p + 1);
          end else begin
            r = t % (2 * p);
            ec = (r <= p) ? r : 2 * p - r;
            ew = t / (2 * p); em = (t + p) / (2 * p);
          end
          rd(2'd1, v);
          chk(md == 1 ? "R5 R3 R2 up count" : "R7 R3 R2 updown count", v, ec);
          chk(md == 1 ? "R5 R11 up wraps" : "R7 R11 updown wraps", n_wrap, ew);
          chk(md == 1 ? "R5 R11 up matches" : "R7 R11 updown matches", n_match, em);
        end
      end
    end

    // R2 unselected sources ignored
    start(2, 0, 2, 0);
    pulses(6, 4'b1011);
    rd(2'd1, v); chk("R2 unselected ignored", v, 0);

    // R6 continuous rollover, R10 load
    start(2, 0, 0, 1);
    wr(2'd1, 16'hFFFD);
    rd(2'd1, v); chk("R10 count load", v, 16'hFFFD);
    n_match = 0; n_wrap = 0;
    pulses(5, 4'b0001);
    rd(2'd1, v); chk("R6 rollover count", v, 2);
    chk("R6 rollover wrap", n_wrap, 1);
    chk("R6 period match", n_match, 1);
    start(2, 2, 3, 100);
    wr(2'd1, 16'd10);
    pulses(12, 4'b1000);
    rd(2'd1, v); chk("R6 R3 cont div4", v, 13);

    // R8 zero period halts and restarts
    start(1, 0, 0, 3);
    pulses(2, 4'b0001);
    wr(2'd2, 16'd0);
    pulses(4, 4'b0001);
    rd(2'd1, v); chk("R8 halted count", v, 2);
    wr(2'd2, 16'd5);
    rd(2'd1, v); chk("R8 restart zero", v, 0);
    pulses(3, 4'b0001);
    rd(2'd1, v); chk("R8 resumed", v, 3);

    // R9 clear resets prescaler
    start(2, 3, 0, 0);
    pulses(5, 4'b0001);
    wr(2'd0, ctl(0, 3, 2, 1'b1));
    pulses(7, 4'b0001);
    rd(2'd1, v); chk("R9 prescaler cleared", v, 0);
    rd(2'd0, v); chk("R9 clear bit not stored", v, int'(ctl(0, 3, 2, 1'b0)));
    // R9 clear resets direction
    start(3, 0, 0, 2);
    pulses(3, 4'b0001);
    rd(2'd1, v); chk("R7 descending", v, 1);
    wr(2'd0, ctl(0, 0, 3, 1'b1));
    pulses(1, 4'b0001);
    rd(2'd1, v); chk("R9 direction cleared", v, 1);

    // R10 unused address
    rd(2'd3, v); chk("R10 addr3 zero", v, 0);
    rd(2'd2, v); chk("R10 period readback", v, 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule